// File: doc/BRIEF.md
# Station-Management Power-Up Sequencer

This block is the master side of a two-wire station-management bus (MDC clock, bidirectional MDIO data) shared by several Ethernet PHYs, each selected by its own 5-bit address. Once reset is released it puts every PHY into power-down without any help from the host. It sends three register-0 writes with the power-down bit set. The first goes to the broadcast address 0, the second to the primary PHY address and the third to the secondary PHY address. The primary and secondary addresses come in on input pins. The PHY built into the same chip answers at address 5'b10000, so that value is normally tied to the primary address input.

When the power-down series is done, the block carries out read and write transactions requested by the host. Requests that arrive while the series is still running are not rejected. They go into a small queue and are executed in arrival order afterwards. MDC is produced by dividing the system clock. Each transaction ends with a single-cycle done pulse. For a read, the 16 data bits returned by the PHY appear on a data output at the same time as that pulse.

Top module: `mgmt_pwrup_master`

## Requirements
- R1: Each frame has 64 bits sent MSB first. In order they are: 32 ones, start code 01, an opcode (01 write, 10 read), the 5-bit PHY address, the 5-bit register address, a 2-bit turnaround (10 on a write), then 16 data bits. Unused data bits of a read are 0 in the frame word.
- R2: The first frame after reset writes 16'h0800 (bit 11, power-down) to register 0 of PHY address 0.
- R3: The second frame writes 16'h0800 to register 0 at the address on pri_addr. The third frame does the same at the address on sec_addr.
- R4: busy is high from reset until the power-down series is finished, the queue is empty and no frame is in progress. A request is taken when req_valid and req_ready are both high. req_ready is low while the REQ_DEPTH-entry queue is full, and a request offered then is dropped. Queued requests are executed in arrival order.
- R5: MDC runs without stopping. It is high for MDC_HALF system clocks and then low for MDC_HALF system clocks (33 and 33 by default, which is 660 ns at 100 MHz).
- R6: mdio_o and mdio_oe change only on the clock edge where MDC falls, and mdio_oe is low whenever busy is low.
- R7: On a read, mdio_oe is high for the first 46 bits only, which means MDIO is released from the turnaround onward. mdio_i is sampled at the MDC rise of each of the 16 data bits, and rd_data takes the result, MSB first, in the cycle done is high. rd_data changes at no other time.
- R8: done is high for exactly one cycle at the end of each host transaction. It does not pulse for the three power-down frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pri_addr | input | 5 | Primary PHY address |
| sec_addr | input | 5 | Secondary PHY address |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Queue can take a request |
| req_write | input | 1 | 1 write, 0 read |
| req_phy | input | 5 | PHY address of the request |
| req_reg | input | 5 | Register address of the request |
| req_wdata | input | 16 | Write data |
| busy | output | 1 | Series, queue or frame pending |
| done | output | 1 | Host transaction finished (one cycle) |
| rd_data | output | 16 | Data returned by the last read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO data driven by the master |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO data seen on the bus |

## Verification
The bench connects a model PHY to the bus that records every frame bit by bit at the MDC rise and also records whether the master was driving each bit. The power-down series is checked with a non-zero primary and secondary address, so a swapped or reused address gives the wrong frame. Two host requests, a write and a read, are queued while the series is still running, and a third is offered against a full queue; this shows that queued requests are held and then served in order, and that a request offered to a full queue is dropped. A table of writes and reads uses several addresses and data words with alternating and asymmetric bit patterns, so that bit-order, opcode and turnaround faults are caught. A write placed after a read shows that rd_data keeps the read value.

// File: rtl/mgmt_pkg.sv
package mgmt_pkg;
  localparam int unsigned FRAME_BITS  = 64;
  localparam int unsigned RD_DRIVEN   = 46;  // bits driven on a read
  localparam int unsigned DATA_FIRST  = 48;  // index of the first data bit
  localparam logic [4:0]  BCAST_ADDR  = 5'd0;
  localparam logic [15:0] PWRDN_WORD  = 16'h0800;

  typedef struct packed {
    logic        write;
    logic [4:0]  phy;
    logic [4:0]  regad;
    logic [15:0] wdata;
  } mgmt_req_t;

  typedef enum logic [1:0] {SQ_BCAST, SQ_PRI, SQ_SEC, SQ_HOST} seq_state_e;
endpackage

// File: rtl/mdc_clkgen.sv
module mdc_clkgen #(
  parameter int unsigned HALF = 33
) (
  input  logic clk,
  input  logic rst_n,
  output logic mdc,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          mdc_q, mdc_d;
  logic          term;

  assign term = (cnt_q == CW'(HALF - 1));

  always_comb begin
    cnt_d = term ? '0 : cnt_q + 1'b1;
    mdc_d = term ? ~mdc_q : mdc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc       = mdc_q;
  assign rise_tick = term & ~mdc_q;
  assign fall_tick = term & mdc_q;
endmodule

// File: rtl/mgmt_req_fifo.sv
module mgmt_req_fifo
  import mgmt_pkg::*;
#(
  parameter int unsigned DEPTH = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      push,
  input  mgmt_req_t push_data,
  input  logic      pop,
  output mgmt_req_t head,
  output logic      empty,
  output logic      full
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned NW = $clog2(DEPTH + 1);

  mgmt_req_t       mem_q [DEPTH];
  logic [AW-1:0]   wr_q, wr_d, rd_q, rd_d;
  logic [NW-1:0]   num_q, num_d;
  logic            do_push, do_pop;

  assign empty   = (num_q == '0);
  assign full    = (num_q == NW'(DEPTH));
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign head    = mem_q[rd_q];

  always_comb begin
    wr_d  = wr_q;
    rd_d  = rd_q;
    num_d = num_q;
    if (do_push) wr_d = (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
    if (do_pop)  rd_d = (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
    if (do_push && !do_pop) num_d = num_q + 1'b1;
    else if (!do_push && do_pop) num_d = num_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      num_q <= '0;
    end else begin
      wr_q  <= wr_d;
      rd_q  <= rd_d;
      num_q <= num_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (do_push && wr_q == AW'(g)) mem_q[g] <= push_data;
    end
  end
endmodule

// File: rtl/mgmt_frame_engine.sv
module mgmt_frame_engine
  import mgmt_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rise_tick,
  input  logic        fall_tick,
  input  logic        start,
  input  mgmt_req_t   req,
  input  logic        mdio_i,
  output logic        mdio_o,
  output logic        mdio_oe,
  output logic        active,
  output logic        done,
  output logic [15:0] rd_data
);
  localparam int unsigned CNTW = $clog2(FRAME_BITS + 1);

  logic                  act_q, act_d;
  logic                  wr_q, wr_d;
  logic [FRAME_BITS-1:0] sh_q, sh_d;
  logic [CNTW-1:0]       cnt_q, cnt_d;
  logic                  mdo_q, mdo_d;
  logic                  oe_q, oe_d;
  logic [15:0]           rsh_q, rsh_d;
  logic [15:0]           rd_q, rd_d;
  logic                  done_q, done_d;

  always_comb begin
    act_d  = act_q;
    wr_d   = wr_q;
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    mdo_d  = mdo_q;
    oe_d   = oe_q;
    rsh_d  = rsh_q;
    rd_d   = rd_q;
    done_d = 1'b0;
    if (!act_q) begin
      if (start) begin
        act_d = 1'b1;
        wr_d  = req.write;
        cnt_d = '0;
        sh_d  = {32'hFFFF_FFFF, 2'b01,
                 req.write ? 2'b01 : 2'b10,
                 req.phy, req.regad,
                 req.write ? 2'b10 : 2'b00,
                 req.write ? req.wdata : 16'h0000};
      end
    end else begin
      if (fall_tick) begin
        if (cnt_q == CNTW'(FRAME_BITS)) begin
          act_d  = 1'b0;
          oe_d   = 1'b0;
          mdo_d  = 1'b1;
          done_d = 1'b1;
          if (!wr_q) rd_d = rsh_q;
        end else begin
          mdo_d = sh_q[FRAME_BITS-1];
          sh_d  = {sh_q[FRAME_BITS-2:0], 1'b0};
          oe_d  = wr_q | (cnt_q < CNTW'(RD_DRIVEN));
          cnt_d = cnt_q + 1'b1;
        end
      end
      if (rise_tick && !wr_q && cnt_q > CNTW'(DATA_FIRST)) begin
        rsh_d = {rsh_q[14:0], mdio_i};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      sh_q   <= '0;
      cnt_q  <= '0;
      mdo_q  <= 1'b1;
      oe_q   <= 1'b0;
      rsh_q  <= '0;
      rd_q   <= '0;
      done_q <= 1'b0;
    end else begin
      act_q  <= act_d;
      wr_q   <= wr_d;
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      mdo_q  <= mdo_d;
      oe_q   <= oe_d;
      rsh_q  <= rsh_d;
      rd_q   <= rd_d;
      done_q <= done_d;
    end
  end

  assign mdio_o  = mdo_q;
  assign mdio_oe = oe_q;
  assign active  = act_q;
  assign done    = done_q;
  assign rd_data = rd_q;
endmodule

// File: rtl/mgmt_pwrup_master.sv
module mgmt_pwrup_master
  import mgmt_pkg::*;
#(
  parameter int unsigned MDC_HALF  = 33,
  parameter int unsigned REQ_DEPTH = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [4:0]  pri_addr,
  input  logic [4:0]  sec_addr,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [4:0]  req_phy,
  input  logic [4:0]  req_reg,
  input  logic [15:0] req_wdata,
  output logic        busy,
  output logic        done,
  output logic [15:0] rd_data,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  seq_state_e st_q, st_d;
  logic       launched_q, launched_d;
  logic       start, pop;
  logic       q_empty, q_full;
  logic       rise_tick, fall_tick;
  logic       eng_active, eng_done;
  mgmt_req_t  q_head, sel_req, in_req;

  assign in_req = '{write: req_write, phy: req_phy, regad: req_reg, wdata: req_wdata};

  mdc_clkgen #(.HALF(MDC_HALF)) clkgen_i (
    .clk(clk), .rst_n(rst_n), .mdc(mdc),
    .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  mgmt_req_fifo #(.DEPTH(REQ_DEPTH)) fifo_i (
    .clk(clk), .rst_n(rst_n),
    .push(req_valid), .push_data(in_req),
    .pop(pop), .head(q_head), .empty(q_empty), .full(q_full)
  );

  mgmt_frame_engine engine_i (
    .clk(clk), .rst_n(rst_n),
    .rise_tick(rise_tick), .fall_tick(fall_tick),
    .start(start), .req(sel_req), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .active(eng_active), .done(eng_done), .rd_data(rd_data)
  );

  always_comb begin
    st_d       = st_q;
    launched_d = launched_q;
    start      = 1'b0;
    pop        = 1'b0;
    sel_req    = '{write: 1'b1, phy: BCAST_ADDR, regad: 5'd0, wdata: PWRDN_WORD};
    unique case (st_q)
      SQ_BCAST: sel_req.phy = BCAST_ADDR;
      SQ_PRI:   sel_req.phy = pri_addr;
      SQ_SEC:   sel_req.phy = sec_addr;
      default:  sel_req     = q_head;
    endcase
    if (!launched_q && !eng_active && (st_q != SQ_HOST || !q_empty)) begin
      start      = 1'b1;
      pop        = (st_q == SQ_HOST);
      launched_d = 1'b1;
    end
    if (eng_done) begin
      launched_d = 1'b0;
      unique case (st_q)
        SQ_BCAST: st_d = SQ_PRI;
        SQ_PRI:   st_d = SQ_SEC;
        default:  st_d = SQ_HOST;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= SQ_BCAST;
      launched_q <= 1'b0;
    end else begin
      st_q       <= st_d;
      launched_q <= launched_d;
    end
  end

  assign req_ready = ~q_full;
  assign busy      = (st_q != SQ_HOST) | launched_q | ~q_empty;
  assign done      = eng_done & (st_q == SQ_HOST);
endmodule

// File: rtl/mgmt_pwrup_checker.sv
module mgmt_pwrup_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe,
  input logic        busy,
  input logic        done,
  input logic        req_ready,
  input logic [15:0] rd_data
);
  // R6: drive enable moves only with a falling MDC
  p_oe_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_oe != $past(mdio_oe)) |-> $fell(mdc));

  // R6: data moves only with a falling MDC
  p_data_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mdio_o != $past(mdio_o)) |-> $fell(mdc));

  // R6: bus released when idle
  p_idle_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);

  // R8: done lasts one cycle
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7: read data only moves together with done
  p_rdata_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rd_data) |-> done);

  // R4: a full queue implies pending work
  p_full_means_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !req_ready |-> busy);
endmodule

bind mgmt_pwrup_master mgmt_pwrup_checker chk_i (.*);

// File: tb/mgmt_pwrup_master_tb_top.sv
module mgmt_pwrup_master_tb_top;
  localparam logic [4:0] PRI = 5'b10000;
  localparam logic [4:0] SEC = 5'h03;
  localparam int NVEC = 4;
  // {write, phy, reg, wdata, phy response}
  localparam logic [42:0] VEC [NVEC] = '{
    {1'b1, 5'h10, 5'h04, 16'hA5C3, 16'h0000},
    {1'b0, 5'h10, 5'h02, 16'h0000, 16'h003B},
    {1'b0, 5'h1F, 5'h1F, 16'h0000, 16'hC001},
    {1'b1, 5'h03, 5'h00, 16'h1200, 16'h0000}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [4:0] req_phy = '0, req_reg = '0;
  logic [15:0] req_wdata = '0;
  logic req_ready, busy, done, mdc, mdio_o, mdio_oe;
  logic [15:0] rd_data;
  logic mdio_i = 1'b1;

  int n_checks = 0, n_err = 0;
  logic [63:0] cap_frame [16];
  logic [63:0] cap_oe [16];
  int nframes = 0, nbit = 0, done_cnt = 0;
  logic in_frame = 1'b0;
  logic [63:0] cur, cur_oe;
  logic [15:0] phy_resp = 16'h0000;

  always #5 clk = ~clk;

  mgmt_pwrup_master dut_i (
    .clk(clk), .rst_n(rst_n), .pri_addr(PRI), .sec_addr(SEC),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_phy(req_phy), .req_reg(req_reg), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rd_data(rd_data),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  // model PHY: records each bit at the MDC rise
  always @(posedge mdc) begin
    if (!in_frame && mdio_oe) begin
      in_frame = 1'b1;
      nbit = 0;
    end
    if (in_frame) begin
      cur[63-nbit]    = mdio_oe ? mdio_o : 1'b0;
      cur_oe[63-nbit] = mdio_oe;
      nbit++;
      if (nbit == 64) begin
        if (nframes < 16) begin
          cap_frame[nframes] = cur;
          cap_oe[nframes]    = cur_oe;
        end
        nframes++;
        in_frame = 1'b0;
      end
    end
  end

  always @(negedge mdc) begin
    if (in_frame && nbit >= 48 && nbit < 64) mdio_i = phy_resp[63-nbit];
    else mdio_i = 1'b1;
  end

  always @(posedge clk) if (done) done_cnt++;

  function automatic logic [63:0] exp_frame(input logic w, input logic [4:0] p,
                                            input logic [4:0] r, input logic [15:0] d);
    return {32'hFFFF_FFFF, 2'b01, w ? 2'b01 : 2'b10, p, r,
            w ? 2'b10 : 2'b00, w ? d : 16'h0000};
  endfunction

  function automatic logic [63:0] exp_oe(input logic w);
    return w ? {64{1'b1}} : {{46{1'b1}}, 18'h0};
  endfunction

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  task automatic offer(input logic w, input logic [4:0] p, input logic [4:0] r,
                       input logic [15:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_phy = p; req_reg = r; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    time t0, t1, t2;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R4 busy after reset", 64'(busy), 64'd1);
    chk("R6 released after reset", 64'(mdio_oe), 64'd0);
    chk("R4 ready after reset", 64'(req_ready), 64'd1);
    chk("R8 no done after reset", 64'(done), 64'd0);

    // two requests queued during the series, a third against a full queue
    offer(1'b1, 5'h10, 5'h00, 16'h3100);
    offer(1'b0, 5'h03, 5'h01, 16'h0000);
    chk("R4 ready low when full", 64'(req_ready), 64'd0);
    offer(1'b1, 5'h07, 5'h07, 16'hFFFF);
    chk("R4 busy while queued", 64'(busy), 64'd1);

    @(posedge mdc); t0 = $time;
    @(negedge mdc); t1 = $time;
    @(posedge mdc); t2 = $time;
    chk("R5 mdc high time", 64'((t1 - t0) / 10), 64'd33);
    chk("R5 mdc low time", 64'((t2 - t1) / 10), 64'd33);

    phy_resp = 16'h796D;
    while (busy) @(negedge clk);
    chk("R2 broadcast power-down", cap_frame[0], exp_frame(1'b1, 5'd0, 5'd0, 16'h0800));
    chk("R3 primary power-down", cap_frame[1], exp_frame(1'b1, PRI, 5'd0, 16'h0800));
    chk("R3 secondary power-down", cap_frame[2], exp_frame(1'b1, SEC, 5'd0, 16'h0800));
    chk("R1 write frame drive", cap_oe[2], exp_oe(1'b1));
    chk("R4 first queued served", cap_frame[3], exp_frame(1'b1, 5'h10, 5'h00, 16'h3100));
    chk("R4 second queued served", cap_frame[4], exp_frame(1'b0, 5'h03, 5'h01, 16'h0));
    chk("R7 read release", cap_oe[4], exp_oe(1'b0));
    chk("R7 read data", 64'(rd_data), 64'h796D);
    chk("R4 full-queue offer dropped", 64'(nframes), 64'd5);
    chk("R8 done only for host", 64'(done_cnt), 64'd2);

    for (int i = 0; i < NVEC; i++) begin
      logic w;
      logic [4:0] p, r;
      logic [15:0] d, resp, prev_rd;
      {w, p, r, d, resp} = VEC[i];
      phy_resp = resp;
      prev_rd = rd_data;
      offer(w, p, r, d);
      while (!done) @(negedge clk);
      @(negedge clk);
      chk("R8 done one cycle", 64'(done), 64'd0);
      chk("R1 vector frame", cap_frame[nframes-1], exp_frame(w, p, r, d));
      chk("R7 vector drive enable", cap_oe[nframes-1], exp_oe(w));
      if (w) chk("R7 rd_data held on write", 64'(rd_data), 64'(prev_rd));
      else   chk("R7 vector read data", 64'(rd_data), 64'(resp));
      chk("R4 idle after vector", 64'(busy), 64'd0);
    end
    chk("R8 done count", 64'(done_cnt), 64'd6);
    finish_run();
  end
endmodule